// File: doc/BRIEF.md
# Serial Byte Receiver with Backlog Throttle

This block turns an asynchronous serial line into bytes. The line rests high. A frame is made of one low start bit, eight data bits with the least significant bit first, and one high stop bit. The bit period is the integer quotient of the clock frequency by the baud rate. Both are compile-time parameters, and the defaults of 25 MHz and 115200 baud give 217 cycles per bit. The line passes through a two-flop synchronizer. A start bit counts only if the line is still low half a bit period after the falling edge. Each later bit is sampled at its centre.

Completed bytes go into a small in-order queue. A consumer takes them with a valid/ready handshake. The block also drives a stop-sending output that tells the far-end transmitter to pause. That output is high while the unread backlog is two bytes or more, and low otherwise. When the consumer removes one byte from a backlog of two, exactly one more frame can land before the pause comes back. The queue has room for frames that were already in flight when the pause was raised. If a byte completes while the queue is full, the byte is lost and a sticky overrun flag is set.

Top module: `uart_rx_fc`

## Requirements
- R1: A frame of one low start bit, eight data bits least significant bit first and one high stop bit yields on data_o the byte carried by the data bits.
- R2: With the default parameters, valid_o rises fewer than 2100 clock cycles after the falling edge of the start bit, which is inside the stop bit.
- R3: stop_send_o is high whenever two or more received bytes are waiting unread.
- R4: Popping one byte from a backlog of exactly two lowers stop_send_o in the following cycle. When one further byte then lands, stop_send_o goes high again.
- R5: stop_send_o is low whenever one or zero bytes are waiting, and this includes the empty queue.
- R6: Bytes leave in arrival order. A byte is removed only on a cycle where valid_o and ready_i are both high, and while valid_o is high and ready_i is low, data_o holds its value.
- R7: A low pulse on rx_i shorter than half a bit period is not taken as a start bit and produces no byte.
- R8: If the stop bit samples low, the frame is discarded and the receiver waits for rx_i to return high before it looks for a new start bit. A following correct frame is received intact.
- R9: The queue holds DEPTH bytes, 4 by default. A byte that completes while the queue is full is dropped, the queued bytes are kept, and overrun_o goes high and stays high until reset.
- R10: After reset, valid_o, stop_send_o and overrun_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high, asynchronous to clk_i |
| data_o | output | 8 | Oldest unread byte |
| valid_o | output | 1 | data_o holds an unread byte |
| ready_i | input | 1 | Consumer takes data_o on a cycle where valid_o is high |
| stop_send_o | output | 1 | Asks the far-end transmitter to pause |
| overrun_o | output | 1 | Sticky flag: a byte was lost because the queue was full |

## Verification
The bench goes after the edges of the throttle. It checks that the pause is raised at a backlog of two, and that a design counting a backlog of three would fail to do so. It checks that the pause is lowered in the cycle after one pop. A design that waited for a full drain would starve the sender there. It also checks that the pause is raised again after exactly one more frame. Short low glitches must not produce phantom bytes, and a frame with a low stop bit must be thrown away without losing the frame that follows it. The bench also overfills the queue while ignoring the pause. A design that overwrote the oldest entry, or that cleared the overrun flag on a pop, is caught by comparing the bytes in order and by watching the flag.

// File: rtl/uart_rx_fc_pkg.sv
package uart_rx_fc_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_RECOVER
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_fc_pkg::*;
#(
  parameter int CPB   = 217,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  output logic [WIDTH-1:0] byte_o,
  output logic             done_o
);
  localparam int CW   = (CPB > 2) ? $clog2(CPB) : 2;
  localparam int BW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int HALF = CPB / 2;

  rx_state_e        state_q;
  logic [CW-1:0]    cnt_q;
  logic [BW-1:0]    idx_q;
  logic [WIDTH-1:0] shreg_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!rx_i) state_q <= RX_START;
        end
        RX_START: begin
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            // low at mid-bit confirms the start bit
            state_q <= rx_i ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CW'(CPB - 1)) begin
            cnt_q   <= '0;
            shreg_q <= {rx_i, shreg_q[WIDTH-1:1]};
            if (idx_q == BW'(WIDTH - 1)) state_q <= RX_STOP;
            else                         idx_q   <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == CW'(CPB - 1)) begin
            cnt_q <= '0;
            if (rx_i) begin
              done_q  <= 1'b1;
              state_q <= RX_IDLE;
            end else begin
              state_q <= RX_RECOVER;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_RECOVER: begin
          if (rx_i) state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign byte_o = shreg_q;
  assign done_o = done_q;
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int WIDTH      = 8,
  parameter int DEPTH      = 4,
  parameter int CORK_LEVEL = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [WIDTH-1:0]           push_data_i,
  input  logic                       pop_i,
  output logic [WIDTH-1:0]           rd_data_o,
  output logic                       not_empty_o,
  output logic [$clog2(DEPTH+1)-1:0] fill_o,
  output logic                       cork_o,
  output logic                       overrun_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [FW-1:0]    fill_q;
  logic             ovr_q;
  logic             full, do_push, do_pop;

  assign full    = (fill_q == FW'(DEPTH));
  assign do_pop  = pop_i && (fill_q != '0);
  assign do_push = push_i && !full;

  function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (do_push) wr_q <= wrap_inc(wr_q);
      if (do_pop)  rd_q <= wrap_inc(rd_q);
      unique case ({do_push, do_pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
      if (push_i && full) ovr_q <= 1'b1;
    end
  end

  assign rd_data_o   = mem_q[rd_q];
  assign not_empty_o = (fill_q != '0);
  assign fill_o      = fill_q;
  assign cork_o      = (fill_q >= FW'(CORK_LEVEL));
  assign overrun_o   = ovr_q;
endmodule

// File: rtl/uart_rx_fc.sv
module uart_rx_fc #(
  parameter int CLK_HZ      = 25_000_000,
  parameter int BAUD        = 115_200,
  parameter int DEPTH       = 4,
  parameter int CORK_LEVEL  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  input  logic       ready_i,
  output logic       stop_send_o,
  output logic       overrun_o
);
  localparam int CPB = CLK_HZ / BAUD;
  localparam int FW  = $clog2(DEPTH + 1);

  logic          rx_s;
  logic [7:0]    rx_byte;
  logic          byte_done;
  logic [FW-1:0] fill;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_rx_deser #(.CPB(CPB), .WIDTH(8)) u_deser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_s),
    .byte_o(rx_byte),
    .done_o(byte_done)
  );

  uart_rx_queue #(.WIDTH(8), .DEPTH(DEPTH), .CORK_LEVEL(CORK_LEVEL)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (byte_done),
    .push_data_i(rx_byte),
    .pop_i      (ready_i),
    .rd_data_o  (data_o),
    .not_empty_o(valid_o),
    .fill_o     (fill),
    .cork_o     (stop_send_o),
    .overrun_o  (overrun_o)
  );
endmodule

// File: rtl/uart_rx_fc_chk.sv
module uart_rx_fc_chk #(
  parameter int DEPTH      = 4,
  parameter int CORK_LEVEL = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [7:0]                 data_o,
  input logic                       valid_o,
  input logic                       ready_i,
  input logic                       stop_send_o,
  input logic                       overrun_o,
  input logic                       byte_done,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int FW = $clog2(DEPTH + 1);

  assert_empty_no_cork_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !stop_send_o);

  assert_release_on_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill == FW'(CORK_LEVEL) && valid_o && ready_i && !byte_done) |=> !stop_send_o);

  assert_hold_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  assert_overrun_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  assert_overrun_on_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && fill == FW'(DEPTH)) |=> overrun_o);

  assert_fill_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= FW'(DEPTH));
endmodule

bind uart_rx_fc uart_rx_fc_chk #(.DEPTH(DEPTH), .CORK_LEVEL(CORK_LEVEL)) u_chk (.*);

// File: tb/sim_uart_rx_fc.sv
`timescale 1ns/1ps
module sim_uart_rx_fc;
  localparam int CPB   = 25_000_000 / 115_200;
  localparam int DEPTH = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic       ready_i = 1'b0;
  logic [7:0] data_o;
  logic       valid_o, stop_send_o, overrun_o;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q[$];

  always #2 clk_i = ~clk_i;

  uart_rx_fc u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .data_o(data_o),
    .valid_o(valid_o), .ready_i(ready_i), .stop_send_o(stop_send_o),
    .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: takes the scoreboard's front entry whenever a handshake is set up
  always @(negedge clk_i) begin
    if (rst_ni && valid_o && ready_i) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected byte", data_o, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(data_o == e, "R6/R1 byte order and value", data_o, e);
      end
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);
    #1;
  endtask

  task automatic drive_bit(input logic b);
    rx_i = b;
    repeat (CPB) @(posedge clk_i);
    #1;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_b);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit(stop_b);
    rx_i = 1'b1;
  endtask

  // driver: pushes the expected byte onto the scoreboard, then sends it
  task automatic send_good(input logic [7:0] b, input bit expect_kept);
    if (expect_kept) exp_q.push_back(b);
    send_frame(b, 1'b1);
  endtask

  task automatic pop_one();
    @(posedge clk_i); #1 ready_i = 1'b1;
    @(posedge clk_i); #1 ready_i = 1'b0;
  endtask

  task automatic idle_bits(input int n);
    rx_i = 1'b1;
    repeat (n * CPB) @(posedge clk_i);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R10 valid after reset", valid_o, 0);
    chk(stop_send_o == 1'b0, "R10 stop_send after reset", stop_send_o, 0);
    chk(overrun_o == 1'b0, "R10 overrun after reset", overrun_o, 0);
    @(posedge clk_i); #1;

    // R2: latency from the start edge to valid_o
    begin
      int lat = 0;
      exp_q.push_back(8'd77);
      fork
        send_frame(8'd77, 1'b1);
        begin
          while (!valid_o && lat < 3000) begin
            @(negedge clk_i);
            lat++;
          end
        end
      join
      chk(lat < 2100, "R2 byte ready during stop bit", lat, 2099);
    end
    @(negedge clk_i);
    chk(data_o == 8'd77, "R1 single byte value", data_o, 77);
    chk(stop_send_o == 1'b0, "R5 one byte waiting no pause", stop_send_o, 0);
    pop_one();
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R6 queue empty after pop", valid_o, 0);
    idle_bits(2);

    // throttle sequence
    send_good(8'd42, 1);
    send_good(8'd59, 1);
    @(negedge clk_i);
    chk(stop_send_o == 1'b1, "R3 pause at backlog two", stop_send_o, 1);
    repeat (50) @(negedge clk_i);
    chk(data_o == 8'd42, "R6 data held while not ready", data_o, 42);
    chk(valid_o == 1'b1, "R6 valid held while not ready", valid_o, 1);
    @(posedge clk_i); #1;
    pop_one();
    @(negedge clk_i);
    chk(stop_send_o == 1'b0, "R4 pause released after one pop", stop_send_o, 0);
    @(posedge clk_i); #1;
    send_good(8'd14, 1);
    @(negedge clk_i);
    chk(stop_send_o == 1'b1, "R4 pause back after one more byte", stop_send_o, 1);
    @(posedge clk_i); #1;
    pop_one();
    @(negedge clk_i);
    chk(stop_send_o == 1'b0, "R5 pause low at backlog one", stop_send_o, 0);
    @(posedge clk_i); #1;
    pop_one();
    @(negedge clk_i);
    chk(valid_o == 1'b0 && stop_send_o == 1'b0, "R5 empty queue no pause",
        {valid_o, stop_send_o}, 0);
    @(posedge clk_i); #1;
    idle_bits(1);

    // R1: bit order with edge patterns
    send_good(8'h01, 1);
    send_good(8'h80, 1);
    pop_one();
    pop_one();
    send_good(8'h00, 1);
    send_good(8'hFF, 1);
    pop_one();
    pop_one();
    @(negedge clk_i);
    chk(exp_q.size() == 0, "R1 pattern bytes all delivered", exp_q.size(), 0);
    @(posedge clk_i); #1;

    // R7: short glitch
    rx_i = 1'b0;
    repeat (CPB / 4) @(posedge clk_i);
    #1 rx_i = 1'b1;
    idle_bits(12);
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R7 glitch produced no byte", valid_o, 0);
    @(posedge clk_i); #1;

    // R8: low stop bit, line held low a while
    send_frame(8'h3C, 1'b0);
    rx_i = 1'b0;
    repeat (2 * CPB) @(posedge clk_i);
    #1;
    idle_bits(2);
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R8 framing error discarded", valid_o, 0);
    @(posedge clk_i); #1;
    send_good(8'hA5, 1);
    @(negedge clk_i);
    chk(valid_o == 1'b1 && data_o == 8'hA5, "R8 next frame intact", data_o, 8'hA5);
    @(posedge clk_i); #1;
    pop_one();
    idle_bits(1);

    // R9: overfill while ignoring the pause
    for (int i = 0; i < DEPTH + 1; i++) send_good(8'(8'h11 * (i + 1)), i < DEPTH);
    @(negedge clk_i);
    chk(overrun_o == 1'b1, "R9 overrun set when full", overrun_o, 1);
    chk(stop_send_o == 1'b1, "R3 pause with full queue", stop_send_o, 1);
    @(posedge clk_i); #1;
    for (int i = 0; i < DEPTH; i++) pop_one();
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R9 dropped byte not queued", valid_o, 0);
    chk(overrun_o == 1'b1, "R9 overrun sticky after pops", overrun_o, 1);
    chk(exp_q.size() == 0, "R9 kept bytes delivered", exp_q.size(), 0);
    @(posedge clk_i); #1;
    do_reset();
    @(negedge clk_i);
    chk(overrun_o == 1'b0, "R9 overrun cleared by reset", overrun_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule